// File: doc/BRIEF.md
# Up-Counting PWM Time Base with Shadowed Period

This block is the time base of one PWM channel. A counter runs upward from zero to the active period value and then returns to zero. A write port programs the period, a phase value, two compare values, the counter itself and a control word. A small action qualifier turns the counter events into two raw PWM levels. The block offers only divide-by-one counting in the up direction.

The period can be double-buffered. In shadow mode a new period waits in a shadow register and moves to the active register only on a cycle where the counter is zero. The two compare values are always double-buffered in the same way. With phase loading enabled, a synchronization event reloads the counter with the phase value. A sync output forwards that event or marks counter zero, so that several time bases can be chained.

If phase loads keep pulling the counter back before it reaches zero, a pending shadow period is never applied. The block keeps this behaviour on purpose, and the bench reproduces it.

Top module: `pwm_timebase`

## Requirements
- R1: The counter advances by one each cycle while it is below the active period. On the cycle after it equals (or exceeds) the active period it reads 0. `zero_evt` is high while the counter is 0, and `prd_evt` is high while the counter equals the active period.
- R2: With control bit 0 set (shadow mode), a write to address 1 only fills the shadow. `prd_active` takes the shadow value on the cycle after a cycle in which the counter was 0. A write in that same zero cycle waits for the following zero.
- R3: With control bit 0 clear (immediate mode), a write to address 1 appears on `prd_active` on the next cycle.
- R4: With control bit 1 set, a sync event (`sync_in` high, or a forced sync) loads the counter with the phase value (address 2) on the next cycle. With bit 1 clear, sync events leave the counter alone.
- R5: While phase loads keep the counter from reaching 0, a pending shadow period stays unapplied. It is applied after the first zero that follows once the sync pulses stop.
- R6: Control bit 2 selects `sync_out`. When the bit is 0, `sync_out` is the sync event. When the bit is 1, `sync_out` is high while the counter is 0.
- R7: A control write (address 0) with bit 3 set raises a sync event in that same cycle, gated by the phase-enable value held before the write. Bit 3 is never stored.
- R8: Compare A (address 3) and compare B (address 4) are written to shadows that move to the active values at counter zero. `cmpa_evt` and `cmpb_evt` are high while the counter equals the active value.
- R9: Action codes are 2'b00 none, 2'b01 drive low, 2'b10 drive high and 2'b11 invert. Output A uses bits [5:4] on zero and bits [7:6] on compare A. Output B uses bits [9:8] on compare A and bits [11:10] on period. The outputs change on the cycle after the event. When two events coincide, the compare action of A is applied after the zero action, and the period action of B is applied after the compare action.
- R10: A write to address 5 loads the counter on the next cycle. It takes priority over a phase load and over normal counting.
- R11: When a sync load and counter zero fall on the same cycle, the counter takes the phase value, and the shadow period and compares are still transferred.
- R12: In reset the counter, all registers and both PWM outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 period, 2 phase, 3 compare A, 4 compare B, 5 counter) |
| wr_data | input | CW | Write data |
| sync_in | input | 1 | Synchronization pulse from the previous time base |
| cnt | output | CW | Counter value |
| prd_active | output | CW | Active period value |
| zero_evt | output | 1 | Counter equals zero |
| prd_evt | output | 1 | Counter equals active period |
| cmpa_evt | output | 1 | Counter equals active compare A |
| cmpb_evt | output | 1 | Counter equals active compare B |
| sync_out | output | 1 | Sync output toward the next time base |
| pwm_a | output | 1 | Raw PWM output A |
| pwm_b | output | 1 | Raw PWM output B |

## Verification
The bound checker checks on every cycle how the counter steps forward, wraps, loads a written value and loads the phase. It also checks that the active period changes only on a zero cycle or on a period write, and that each PWM output holds unless one of its events fires. The effects that span many cycles can only be shown by the bench's scenarios. These are the shadow period held back indefinitely by repeated phase loads, its release after sync stops, a sync load that coincides with zero, and the ordering of actions when events coincide. A behavioural model in the bench is compared against all outputs on every clock.

// File: rtl/pwm_tb_pkg.sv
// Shared types for the PWM time base: register addresses, action codes and
// the control word layout. Assumes the data width is at least CTRL_W bits.
package pwm_tb_pkg;

    typedef enum logic [2:0] {
        ADDR_CTRL = 3'd0,
        ADDR_PRD  = 3'd1,
        ADDR_PHS  = 3'd2,
        ADDR_CMPA = 3'd3,
        ADDR_CMPB = 3'd4,
        ADDR_CNT  = 3'd5
    } reg_addr_t;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_SET  = 2'b10,
        ACT_TGL  = 2'b11
    } aq_act_t;

    typedef struct packed {
        aq_act_t b_on_prd;      // [11:10]
        aq_act_t b_on_cmpa;     // [9:8]
        aq_act_t a_on_cmpa;     // [7:6]
        aq_act_t a_on_zero;     // [5:4]
        logic    force_sync;    // [3] strobe only, never held
        logic    syncout_zero;  // [2]
        logic    phase_en;      // [1]
        logic    prd_shadow;    // [0]
    } tb_ctrl_t;

    localparam int CTRL_W = $bits(tb_ctrl_t);

    // Applies one action code to an output level.
    function automatic logic aq_apply(input aq_act_t act, input logic lvl);
        case (act)
            ACT_CLR: return 1'b0;
            ACT_SET: return 1'b1;
            ACT_TGL: return ~lvl;
            default: return lvl;
        endcase
    endfunction

endpackage

// File: rtl/pwm_tb_shadow.sv
// One double-buffered register. A write always fills the shadow. In
// immediate mode the write also goes straight to the active value; otherwise
// the active value takes the shadow (as held before any same-cycle write)
// when xfer is high.
module pwm_tb_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         imm,
    input  logic         xfer,
    output logic [W-1:0] act_o
);

    logic [W-1:0] shd_q;
    logic [W-1:0] act_q;

    // Shadow holds the most recent write.
    always_ff @(posedge clk) begin
        if (!rst_n)  shd_q <= '0;
        else if (wr) shd_q <= wdata;
    end

    // Active value: direct write in immediate mode, else transfer on xfer.
    always_ff @(posedge clk) begin
        if (!rst_n)             act_q <= '0;
        else if (imm && wr)     act_q <= wdata;
        else if (!imm && xfer)  act_q <= shd_q;
    end

    assign act_o = act_q;

endmodule

// File: rtl/pwm_tb_regs.sv
// Write decoder and register storage. It holds the control word (without the
// force-sync bit), the phase, and three double-buffered registers: period,
// compare A and compare B. Period follows the shadow-mode bit; the compares
// are always shadowed. Transfers happen on counter zero.
module pwm_tb_regs
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          zero_evt,
    output tb_ctrl_t      ctrl_o,
    output logic [CW-1:0] phase_o,
    output logic [CW-1:0] prd_o,
    output logic [CW-1:0] cmpa_o,
    output logic [CW-1:0] cmpb_o,
    output logic          force_o,
    output logic          cnt_wr_o
);

    localparam int NSH      = 3;
    localparam int IDX_PRD  = 0;
    localparam int IDX_CMPA = 1;
    localparam int IDX_CMPB = 2;

    tb_ctrl_t      ctrl_q;
    tb_ctrl_t      ctrl_nxt;
    logic [CW-1:0] phase_q;
    logic [NSH-1:0] sh_wr;
    logic [NSH-1:0] sh_imm;
    logic [CW-1:0] sh_act [NSH];

    // Decode the written control word; the force bit is a strobe only.
    always_comb begin
        ctrl_nxt            = tb_ctrl_t'(wr_data[CTRL_W-1:0]);
        ctrl_nxt.force_sync = 1'b0;
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)  ctrl_q <= ctrl_nxt;
    end

    // Phase value storage.
    always_ff @(posedge clk) begin
        if (!rst_n)                             phase_q <= '0;
        else if (wr_en && wr_addr == ADDR_PHS)  phase_q <= wr_data;
    end

    // Per-register write strobes and load mode.
    always_comb begin
        sh_wr[IDX_PRD]   = wr_en && (wr_addr == ADDR_PRD);
        sh_wr[IDX_CMPA]  = wr_en && (wr_addr == ADDR_CMPA);
        sh_wr[IDX_CMPB]  = wr_en && (wr_addr == ADDR_CMPB);
        sh_imm[IDX_PRD]  = !ctrl_q.prd_shadow;
        sh_imm[IDX_CMPA] = 1'b0;
        sh_imm[IDX_CMPB] = 1'b0;
    end

    for (genvar k = 0; k < NSH; k++) begin : g_shadow
        pwm_tb_shadow #(.W(CW)) u_sh (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (sh_wr[k]),
            .wdata (wr_data),
            .imm   (sh_imm[k]),
            .xfer  (zero_evt),
            .act_o (sh_act[k])
        );
    end

    assign ctrl_o   = ctrl_q;
    assign phase_o  = phase_q;
    assign prd_o    = sh_act[IDX_PRD];
    assign cmpa_o   = sh_act[IDX_CMPA];
    assign cmpb_o   = sh_act[IDX_CMPB];
    assign force_o  = wr_en && (wr_addr == ADDR_CTRL) && wr_data[3];
    assign cnt_wr_o = wr_en && (wr_addr == ADDR_CNT);

endmodule

// File: rtl/pwm_tb_counter.sv
// Up counter with a fixed next-state priority: counter write, then phase
// load, then wrap at or above the period, then increment. Flags zero and
// period match from the registered count.
module pwm_tb_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic [CW-1:0] wr_val,
    input  logic          sync_load,
    input  logic [CW-1:0] phase,
    input  logic [CW-1:0] prd,
    output logic [CW-1:0] cnt_o,
    output logic          zero_o,
    output logic          prd_match_o
);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nxt;

    // Next count by priority.
    always_comb begin
        if (cnt_wr)            cnt_nxt = wr_val;
        else if (sync_load)    cnt_nxt = phase;
        else if (cnt_q >= prd) cnt_nxt = '0;
        else                   cnt_nxt = cnt_q + 1'b1;
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt;
    end

    assign cnt_o       = cnt_q;
    assign zero_o      = (cnt_q == '0);
    assign prd_match_o = (cnt_q == prd);

endmodule

// File: rtl/pwm_tb_aq.sv
// Action qualifier. It updates two registered PWM levels from the counter
// events. Output A applies the zero action, then the compare-A action.
// Output B applies the compare-A action, then the period action.
module pwm_tb_aq
    import pwm_tb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tb_ctrl_t ctrl,
    input  logic     zero_evt,
    input  logic     cmpa_evt,
    input  logic     prd_evt,
    output logic     pwm_a_o,
    output logic     pwm_b_o
);

    logic a_q, b_q;
    logic a_nxt, b_nxt;

    // Apply the enabled actions in their fixed order.
    always_comb begin
        a_nxt = a_q;
        if (zero_evt) a_nxt = aq_apply(ctrl.a_on_zero, a_nxt);
        if (cmpa_evt) a_nxt = aq_apply(ctrl.a_on_cmpa, a_nxt);
        b_nxt = b_q;
        if (cmpa_evt) b_nxt = aq_apply(ctrl.b_on_cmpa, b_nxt);
        if (prd_evt)  b_nxt = aq_apply(ctrl.b_on_prd, b_nxt);
    end

    // Output level registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_nxt;
            b_q <= b_nxt;
        end
    end

    assign pwm_a_o = a_q;
    assign pwm_b_o = b_q;

endmodule

// File: rtl/pwm_timebase.sv
// PWM time base top. It ties the register file, the counter and the action
// qualifier together, and forms the sync path and the compare strobes.
// Assumes CW >= CTRL_W, so that the control word fits the data bus.
module pwm_timebase
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          sync_in,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] prd_active,
    output logic          zero_evt,
    output logic          prd_evt,
    output logic          cmpa_evt,
    output logic          cmpb_evt,
    output logic          sync_out,
    output logic          pwm_a,
    output logic          pwm_b
);

    tb_ctrl_t      ctrl_q;
    logic [CW-1:0] phase;
    logic [CW-1:0] cmpa_act;
    logic [CW-1:0] cmpb_act;
    logic          force_sync;
    logic          cnt_wr;
    logic          sync_evt;
    logic          sync_load;

    pwm_tb_regs #(.CW(CW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .zero_evt (zero_evt),
        .ctrl_o   (ctrl_q),
        .phase_o  (phase),
        .prd_o    (prd_active),
        .cmpa_o   (cmpa_act),
        .cmpb_o   (cmpb_act),
        .force_o  (force_sync),
        .cnt_wr_o (cnt_wr)
    );

    // Sync event from the input pin or a software force.
    always_comb begin
        sync_evt  = sync_in | force_sync;
        sync_load = sync_evt & ctrl_q.phase_en;
        sync_out  = ctrl_q.syncout_zero ? zero_evt : sync_evt;
    end

    pwm_tb_counter #(.CW(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_wr      (cnt_wr),
        .wr_val      (wr_data),
        .sync_load   (sync_load),
        .phase       (phase),
        .prd         (prd_active),
        .cnt_o       (cnt),
        .zero_o      (zero_evt),
        .prd_match_o (prd_evt)
    );

    // Compare strobes against the active compare values.
    always_comb begin
        cmpa_evt = (cnt == cmpa_act);
        cmpb_evt = (cnt == cmpb_act);
    end

    pwm_tb_aq u_aq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl_q),
        .zero_evt (zero_evt),
        .cmpa_evt (cmpa_evt),
        .prd_evt  (prd_evt),
        .pwm_a_o  (pwm_a),
        .pwm_b_o  (pwm_b)
    );

endmodule

// File: rtl/pwm_timebase_chk.sv
// Property checker for the PWM time base. It is attached to the top by bind
// and observes the ports plus the held control word.
module pwm_timebase_chk
    import pwm_tb_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    wr_addr,
    input logic [CW-1:0] wr_data,
    input logic          sync_in,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] prd_active,
    input logic [CW-1:0] phase,
    input logic          zero_evt,
    input logic          prd_evt,
    input logic          cmpa_evt,
    input logic          pwm_a,
    input logic          pwm_b,
    input tb_ctrl_t      ctrl_q
);

    logic c_cnt_wr, c_prd_wr, c_load;

    always_comb begin
        c_cnt_wr = wr_en && (wr_addr == ADDR_CNT);
        c_prd_wr = wr_en && (wr_addr == ADDR_PRD);
        c_load   = ctrl_q.phase_en &&
                   (sync_in || (wr_en && (wr_addr == ADDR_CTRL) && wr_data[3]));
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < prd_active && !c_cnt_wr && !c_load) |=> cnt == $past(cnt) + 1'b1); // R1
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= prd_active && !c_cnt_wr && !c_load) |=> cnt == '0); // R1
    AST_PRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_evt && !c_prd_wr) |=> $stable(prd_active)); // R5
    AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_load && !c_cnt_wr) |=> cnt == $past(phase)); // R4
    AST_CNT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        c_cnt_wr |=> cnt == $past(wr_data)); // R10
    AST_PWM_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_evt && !cmpa_evt) |=> $stable(pwm_a)); // R9
    AST_PWM_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpa_evt && !prd_evt) |=> $stable(pwm_b)); // R9

endmodule

bind pwm_timebase pwm_timebase_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sync_in    (sync_in),
    .cnt        (cnt),
    .prd_active (prd_active),
    .phase      (phase),
    .zero_evt   (zero_evt),
    .prd_evt    (prd_evt),
    .cmpa_evt   (cmpa_evt),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .ctrl_q     (ctrl_q)
);

// File: tb/tb_pwm_timebase.sv
`timescale 1ns/1ps
module tb_pwm_timebase;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic          sync_in = 1'b0;
    logic [CW-1:0] cnt, prd_active;
    logic          zero_evt, prd_evt, cmpa_evt, cmpb_evt, sync_out, pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural model state
    int mcnt = 0, mprd = 0, mshd = 0, mphs = 0;
    int mcas = 0, mca = 0, mcbs = 0, mcb = 0, mctrl = 0;
    int ma = 0, mb = 0;

    always #4 clk = ~clk;

    pwm_timebase #(.CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_in(sync_in), .cnt(cnt),
        .prd_active(prd_active), .zero_evt(zero_evt), .prd_evt(prd_evt),
        .cmpa_evt(cmpa_evt), .cmpb_evt(cmpb_evt), .sync_out(sync_out),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int app(input int code, input int v);
        case (code)
            1: return 0;
            2: return 1;
            3: return (v != 0) ? 0 : 1;
            default: return v;
        endcase
    endfunction

    // One cycle: drive, compare all outputs with the model, clock, update model.
    task automatic step(input bit we, input int a, input int d, input bit si);
        int force_s, sev, ez, ep, eca, ecb, na, nb, ncnt;
        wr_en = we; wr_addr = a[2:0]; wr_data = d[15:0]; sync_in = si;
        #1;
        force_s = (we && a == 0 && d[3]) ? 1 : 0;
        sev = (si || force_s != 0) ? 1 : 0;
        ez  = (mcnt == 0) ? 1 : 0;
        ep  = (mcnt == mprd) ? 1 : 0;
        eca = (mcnt == mca) ? 1 : 0;
        ecb = (mcnt == mcb) ? 1 : 0;
        chk("R1 cnt", int'(cnt), mcnt);
        chk("R2 prd_active", int'(prd_active), mprd);
        chk("R1 zero_evt", int'(zero_evt), ez);
        chk("R1 prd_evt", int'(prd_evt), ep);
        chk("R8 cmpa_evt", int'(cmpa_evt), eca);
        chk("R8 cmpb_evt", int'(cmpb_evt), ecb);
        chk("R6 sync_out", int'(sync_out), mctrl[2] ? ez : sev);
        chk("R9 pwm_a", int'(pwm_a), ma);
        chk("R9 pwm_b", int'(pwm_b), mb);
        @(posedge clk);
        na = ma;
        if (ez != 0)  na = app((mctrl >> 4) & 3, na);
        if (eca != 0) na = app((mctrl >> 6) & 3, na);
        nb = mb;
        if (eca != 0) nb = app((mctrl >> 8) & 3, nb);
        if (ep != 0)  nb = app((mctrl >> 10) & 3, nb);
        if (we && a == 5)                 ncnt = d & 16'hFFFF;
        else if (mctrl[1] && sev != 0)    ncnt = mphs;
        else if (mcnt >= mprd)            ncnt = 0;
        else                              ncnt = mcnt + 1;
        if (ez != 0 && mctrl[0]) mprd = mshd;
        if (ez != 0) begin mca = mcas; mcb = mcbs; end
        if (we && a == 1) begin
            mshd = d & 16'hFFFF;
            if (!mctrl[0]) mprd = d & 16'hFFFF;
        end
        if (we && a == 2) mphs = d & 16'hFFFF;
        if (we && a == 3) mcas = d & 16'hFFFF;
        if (we && a == 4) mcbs = d & 16'hFFFF;
        if (we && a == 0) mctrl = d & 16'hFF7;
        ma = na; mb = nb; mcnt = ncnt;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 cnt", int'(cnt), 0);
        chk("R12 prd_active", int'(prd_active), 0);
        chk("R12 pwm_a", int'(pwm_a), 0);
        chk("R12 pwm_b", int'(pwm_b), 0);
        rst_n = 1'b1;

        // R3/R9: immediate mode, A high at zero, low at cmpA; B high at cmpA, low at period
        step(1, 0, 16'h660, 0);
        step(1, 3, 3, 0);
        step(1, 4, 5, 0);
        step(1, 1, 7, 0);
        chk("R3 immediate period", int'(prd_active), 7);
        idle(30);

        // R2: shadow mode, period write waits for zero
        step(1, 0, 16'h661, 0);
        while (mcnt != 2) step(0, 0, 0, 0);
        step(1, 1, 12, 0);
        chk("R2 shadow held", int'(prd_active), 7);
        idle(30);
        chk("R2 shadow applied", int'(prd_active), 12);

        // R4/R5: phase loads keep the counter away from zero
        step(1, 2, 4, 0);
        step(1, 0, 16'h663, 0);
        for (int i = 0; i < 80; i++) step(i == 20, 1, 5, mcnt >= 9);
        chk("R5 pending period stuck", int'(prd_active), 12);
        idle(20);
        chk("R5 pending period released", int'(prd_active), 5);

        // R6/R7: sync-out on zero, then pass-through with force sync
        step(1, 0, 16'h667, 0);
        for (int i = 0; i < 15; i++) step(0, 0, 0, i == 3);
        step(1, 0, 16'h66B, 0);
        chk("R7 forced load", int'(cnt), 4);
        step(0, 0, 0, 0);
        chk("R7 force not stored sync_out", int'(sync_out), 0);
        idle(10);

        // R10: counter write beats simultaneous sync
        step(1, 5, 2, 1);
        chk("R10 counter write wins", int'(cnt), 2);
        idle(5);

        // R11: sync on a zero cycle still transfers the shadow
        step(1, 1, 9, 0);
        for (int i = 0; i < 40 && mcnt != 0; i++) step(0, 0, 0, 0);
        step(0, 0, 0, 1);
        chk("R11 phase wins at zero", int'(cnt), 4);
        chk("R11 transfer at zero", int'(prd_active), 9);
        idle(10);

        // R9/R8: toggle actions and compares at zero and at period
        step(1, 3, 0, 0);
        step(1, 4, 9, 0);
        step(1, 0, 16'hFF1, 0);
        idle(40);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule